// File: doc/BRIEF.md
# Vector Byte Funnel Shifter

This block joins two 128-bit vector operands into one 256-bit value, operand A in the upper half and operand B in the lower half. It shifts that value left by a whole number of bytes and keeps the upper 128 bits as the result. Each of the 16 output byte lanes is a selector over the 32 source bytes. The lane's source index is its own lane number plus the shift amount. Byte 0 is the most significant byte of every 128-bit vector.

The shift amount comes from an 8-bit immediate field, read in one of two forms:
- **Narrow form:** only the low nibble is used, so the shift runs from 0 to 15 bytes.
- **Wide form:** the low five bits are used, and any value at or above 16 selects a whole-vector shift, which returns operand B.

Passing the same vector as both operands turns the shift into a byte rotation. The result is captured in a single register stage, and a valid flag follows the input strobe.

Top module: `byte_funnel_shifter`

## Requirements
- R1: When `in_valid` is high at a rising edge, the next `out_result` is the upper 16 bytes of {`opnd_a`,`opnd_b`} shifted left by 8×S bits, where S is the decoded shift. Output lane k (lane 0 = bits 127:120) equals source byte k+S. Source bytes 0–15 are A's bytes and source bytes 16–31 are B's bytes, both most-significant first.
- R2: A decoded shift of 0 yields `opnd_a` unchanged.
- R3: In wide form (`wide_form`=1), `imm_field[4:0]` equal to 16 yields `opnd_b` unchanged.
- R4: In narrow form (`wide_form`=0), S = `imm_field[3:0]`, and bits 7:4 have no effect on the result.
- R5: In wide form, S = `imm_field[4:0]` with values 17–31 treated as 16, and bits 7:5 have no effect on the result.
- R6: With `opnd_a` equal to `opnd_b`, the result is that vector rotated left by S bytes.
- R7: `out_valid` equals `in_valid` from the previous rising edge (one cycle of latency).
- R8: When `in_valid` is low at a rising edge, `out_result` keeps its previous value.
- R9: While `rst_n` is low at a rising edge, `out_result` and `out_valid` are cleared to zero, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and immediate are valid; loads the result register |
| opnd_a | input | 128 | Upper half of the joined source, byte 0 = MSB |
| opnd_b | input | 128 | Lower half of the joined source, byte 0 = MSB |
| imm_field | input | 8 | Shift immediate |
| wide_form | input | 1 | 0: low nibble shift; 1: low five bits, saturating at 16 |
| out_result | output | 128 | Registered shifted result |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |

## Verification
Two of the block's functions can act in the same cycle.

- **Reset against a load.** Reset may arrive together with a load strobe. The bench holds `in_valid` high with new operands while `rst_n` is low, both at start-up and again in the middle of a run. It judges that the cleared state wins: both outputs must read zero.
- **Hold against an operand change.** A hold cycle can coincide with a change of operands or immediate. The bench lowers `in_valid` and changes every input in the same cycle. It then expects the previous result to stay in place with `out_valid` low.

A behavioural reference model shifts the 256-bit concatenation as a plain wide integer and is compared with the outputs on every clock.

// File: rtl/bfs_pkg.sv
// Package bfs_pkg
// Shared encodings for the byte funnel shifter.
// Assumes: one immediate-form select bit chosen by the instruction decoder.
package bfs_pkg;

    // Interpretation of the shift immediate
    typedef enum logic {
        FORM_NARROW = 1'b0,  // low nibble, shift 0..15
        FORM_WIDE   = 1'b1   // low five bits, saturating at the lane count
    } imm_form_e;

endpackage

// File: rtl/bfs_shamt_decode.sv
// Module bfs_shamt_decode
// Turns the shift immediate into a byte shift in the range 0..LANES.
// Narrow form masks the immediate to log2(LANES) bits. Wide form takes
// one more bit and clamps anything above LANES down to LANES.
// Assumes: IMM_W is at least log2(LANES)+1.
module bfs_shamt_decode
    import bfs_pkg::*;
#(
    parameter int LANES = 16,
    parameter int IMM_W = 8,
    localparam int NIB_W = $clog2(LANES),
    localparam int SH_W  = NIB_W + 1
) (
    input  logic [IMM_W-1:0] imm_field,
    input  imm_form_e        form,
    output logic [SH_W-1:0]  shamt
);

    logic [SH_W-1:0] wide_raw;

    // Low bits used by the wide form
    assign wide_raw = imm_field[SH_W-1:0];

    // Select the form and saturate the wide form at a full-vector shift
    always_comb begin
        if (form == FORM_NARROW) begin
            shamt = {1'b0, imm_field[NIB_W-1:0]};
        end else if (wide_raw > SH_W'(LANES)) begin
            shamt = SH_W'(LANES);
        end else begin
            shamt = wide_raw;
        end
    end

endmodule

// File: rtl/bfs_byte_permute.sv
// Module bfs_byte_permute
// Per-lane selection network. It splits {a,b} into 2*LANES source bytes,
// most-significant first, and drives each output lane k from source byte
// k+shamt.
// Assumes: shamt <= LANES, so no index passes the last source byte.
module bfs_byte_permute #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    localparam int VEC_W = LANES * BYTE_W,
    localparam int SRC_N = 2 * LANES,
    localparam int IDX_W = $clog2(SRC_N),
    localparam int SH_W  = $clog2(LANES) + 1
) (
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    input  logic [SH_W-1:0]  shamt,
    output logic [VEC_W-1:0] result
);

    logic [BYTE_W-1:0] src_byte  [SRC_N];
    logic [BYTE_W-1:0] lane_byte [LANES];

    // Unpack the joined source into bytes, byte 0 at the top of operand A
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        if (s < LANES) begin : g_from_a
            assign src_byte[s] = opnd_a[VEC_W-1-s*BYTE_W -: BYTE_W];
        end else begin : g_from_b
            assign src_byte[s] = opnd_b[VEC_W-1-(s-LANES)*BYTE_W -: BYTE_W];
        end
    end

    // One selector per output lane, indexed by lane number plus shift
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0] lane_idx;
        assign lane_idx     = IDX_W'(k) + IDX_W'(shamt);
        assign lane_byte[k] = src_byte[lane_idx];
        assign result[VEC_W-1-k*BYTE_W -: BYTE_W] = lane_byte[k];
    end

endmodule

// File: rtl/bfs_out_stage.sv
// Module bfs_out_stage
// Result and valid register. The result loads only on a strobe, and the
// valid flag follows the strobe. Synchronous active-low reset clears both
// and wins over a strobe in the same cycle.
module bfs_out_stage #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] d,
    output logic [VEC_W-1:0] q,
    output logic             q_valid
);

    // Capture the data on a strobe; reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // Valid tracks the strobe with one cycle of delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
        end
    end

    // R7: the strobe shows up on valid one edge later
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q_valid);
    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !q_valid);

    // R8: no strobe, no change
    assert_hold_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R9: reset clears the stage whatever the strobe does
    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (q == '0 && !q_valid));

endmodule

// File: rtl/byte_funnel_shifter.sv
// Module byte_funnel_shifter
// Top of the vector byte funnel shifter. It decodes the immediate, passes
// the operands through the per-lane permute network and registers the
// result together with its valid flag.
// Assumes: operands and immediate are held stable around the clock edge
// where in_valid is sampled.
module byte_funnel_shifter
    import bfs_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    parameter int IMM_W  = 8,
    localparam int VEC_W = LANES * BYTE_W,
    localparam int SH_W  = $clog2(LANES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    input  logic [IMM_W-1:0] imm_field,
    input  logic             wide_form,
    output logic [VEC_W-1:0] out_result,
    output logic             out_valid
);

    imm_form_e       form;
    logic [SH_W-1:0] shamt;
    logic [VEC_W-1:0] perm_result;

    // Map the form select pin onto the package encoding
    assign form = wide_form ? FORM_WIDE : FORM_NARROW;

    bfs_shamt_decode #(
        .LANES (LANES),
        .IMM_W (IMM_W)
    ) i_decode (
        .imm_field (imm_field),
        .form      (form),
        .shamt     (shamt)
    );

    bfs_byte_permute #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) i_permute (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .shamt  (shamt),
        .result (perm_result)
    );

    bfs_out_stage #(
        .VEC_W (VEC_W)
    ) i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (perm_result),
        .q       (out_result),
        .q_valid (out_valid)
    );

    // R2: a zero shift passes operand A through
    assert_zero_shift_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shamt == '0) |=> out_result == $past(opnd_a));

    // R3: a full-vector shift passes operand B through
    assert_full_shift_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shamt == SH_W'(LANES)) |=> out_result == $past(opnd_b));

    // R4: the narrow form never reaches the full-vector shift
    assert_narrow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_form |-> shamt < SH_W'(LANES));

    // R5: wide-form immediates above the lane count saturate to operand B
    assert_wide_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_form && imm_field[SH_W-1:0] > SH_W'(LANES))
        |=> out_result == $past(opnd_b));

endmodule

// File: tb/test_byte_funnel_shifter.sv
module test_byte_funnel_shifter;

    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] opnd_a = '0;
    logic [VW-1:0] opnd_b = '0;
    logic [7:0]    imm_field = '0;
    logic          wide_form = 1'b0;
    logic [VW-1:0] out_result;
    logic          out_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [VW-1:0] exp_result = '0;
    logic          exp_valid = 1'b0;

    always #5 clk = ~clk;

    byte_funnel_shifter i_byte_funnel_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .imm_field  (imm_field),
        .wide_form  (wide_form),
        .out_result (out_result),
        .out_valid  (out_valid)
    );

    // Vector whose byte i (MSB first) is base + step*i
    function automatic logic [VW-1:0] mk(int base, int step);
        logic [VW-1:0] v = '0;
        for (int i = 0; i < 16; i++) v[VW-1-8*i -: 8] = 8'(base + step * i);
        return v;
    endfunction

    // Reference: shift the joined 256-bit value as one integer
    function automatic logic [VW-1:0] ref_model(logic [VW-1:0] a, logic [VW-1:0] b,
                                                logic [7:0] imm, logic wide);
        int sh;
        logic [2*VW-1:0] t;
        if (!wide) sh = int'(imm & 8'h0F);
        else begin
            sh = int'(imm & 8'h1F);
            if (sh > 16) sh = 16;
        end
        t = {a, b} << (8 * sh);
        return t[2*VW-1:VW];
    endfunction

    task automatic chk(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle from a negedge, update the model at the edge, compare at the next negedge
    task automatic cyc(logic r, logic v, logic [VW-1:0] a, logic [VW-1:0] b,
                       logic [7:0] imm, logic wide, string tag);
        rst_n = r; in_valid = v; opnd_a = a; opnd_b = b; imm_field = imm; wide_form = wide;
        @(posedge clk);
        if (!r) begin
            exp_result = '0; exp_valid = 1'b0;
        end else begin
            if (v) exp_result = ref_model(a, b, imm, wide);
            exp_valid = v;
        end
        @(negedge clk);
        chk(out_result == exp_result, tag, out_result, exp_result);
        chk(out_valid == exp_valid, {tag, " valid R7"}, VW'(out_valid), VW'(exp_valid));
    endtask

    initial begin
        logic [VW-1:0] pa, pb, rot, held;
        @(negedge clk);
        // R9: reset wins over a load strobe
        cyc(0, 1, mk(1, 3), mk(7, 5), 8'h03, 0, "R9 reset with strobe");
        cyc(0, 1, mk(9, 1), mk(2, 2), 8'h05, 1, "R9 reset with strobe");
        chk(out_result == '0, "R9 reset result zero", out_result, '0);

        // R1 / R2: narrow-form sweep over all shifts, two operand patterns
        for (int s = 0; s < 16; s++) begin
            cyc(1, 1, mk(0, 1), mk(16, 1), 8'(s), 0, (s == 0) ? "R2 zero shift" : "R1 narrow sweep");
            if (s == 0) chk(out_result == mk(0, 1), "R2 equals A", out_result, mk(0, 1));
            if (s == 5) chk(out_result == mk(5, 1), "R1 lane k = source k+5", out_result, mk(5, 1));
        end
        for (int s = 0; s < 16; s++)
            cyc(1, 1, mk(8'hA3, 37), mk(8'h5C, 91), 8'(s), 0, "R1 mixed pattern");

        // R4: upper immediate bits ignored in narrow form (0x14 acts as 4)
        cyc(1, 1, mk(0, 1), mk(16, 1), 8'hF4, 0, "R4 narrow upper bits");
        chk(out_result == mk(4, 1), "R4 0xF4 acts as shift 4", out_result, mk(4, 1));
        cyc(1, 1, mk(0, 1), mk(16, 1), 8'h10, 0, "R4 narrow 0x10 is shift 0");
        chk(out_result == mk(0, 1), "R4 0x10 gives A", out_result, mk(0, 1));

        // R3 / R5: wide form
        pa = mk(8'h40, 7); pb = mk(8'h90, 13);
        cyc(1, 1, pa, pb, 8'h10, 1, "R3 full shift");
        chk(out_result == pb, "R3 equals B", out_result, pb);
        cyc(1, 1, pa, pb, 8'h11, 1, "R5 saturate 17");
        chk(out_result == pb, "R5 17 gives B", out_result, pb);
        cyc(1, 1, pa, pb, 8'hFF, 1, "R5 saturate 31");
        chk(out_result == pb, "R5 31 gives B", out_result, pb);
        cyc(1, 1, mk(0, 1), mk(16, 1), 8'hE5, 1, "R5 upper bits ignored");
        chk(out_result == mk(5, 1), "R5 0xE5 acts as shift 5", out_result, mk(5, 1));
        cyc(1, 1, pa, pb, 8'h0C, 1, "R5 wide below 16");

        // R6: rotation with the same vector on both sides
        pa = {32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'hDDDD_DDDD};
        rot = {32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'hDDDD_DDDD, 32'hAAAA_AAAA};
        cyc(1, 1, pa, pa, 8'h04, 0, "R6 rotate");
        chk(out_result == rot, "R6 rotate by 4 bytes", out_result, rot);
        pb = mk(8'h21, 17);
        cyc(1, 1, pb, pb, 8'h09, 0, "R6 rotate 9");
        chk(out_result == {pb[VW-1-72:0], pb[VW-1:VW-72]}, "R6 rotate by 9 bytes",
            out_result, {pb[VW-1-72:0], pb[VW-1:VW-72]});

        // R8: hold while every input changes
        held = out_result;
        cyc(1, 0, mk(3, 3), mk(4, 4), 8'h07, 1, "R8 hold");
        chk(out_result == held, "R8 result held", out_result, held);
        cyc(1, 0, mk(5, 9), mk(6, 2), 8'h10, 1, "R8 hold again");
        chk(out_valid == 1'b0, "R7 valid low after idle", VW'(out_valid), '0);
        cyc(1, 1, mk(5, 9), mk(6, 2), 8'h02, 0, "R7 reload");

        // R9: mid-run reset with a strobe present
        cyc(0, 1, mk(1, 1), mk(2, 2), 8'h03, 0, "R9 mid-run reset");
        chk(out_result == '0 && !out_valid, "R9 cleared mid-run", out_result, '0);
        cyc(1, 1, mk(1, 1), mk(2, 2), 8'h03, 0, "R1 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule